// File: doc/BRIEF.md
# PCI configuration address translator

This block is the host-facing configuration port of a PCI host bridge. Software stores a configuration address in a 32-bit index register and then reads or writes a data window. Each legal data-window access becomes exactly one transaction on a downstream request interface. That transaction carries a translated type-1-style address, byte enables derived from the offset and the size, the write data and the direction. For a read, the returned data goes back to the host unchanged.

The stored index is interpreted in one of three ways. If bit 31 is set, the address passes through and the low two offset bits are merged into it. If bit 31 is clear and bit 0 is set, the address is treated as type-1. If both bits are clear, the address is treated as type-0, and a one-hot device-select field in bits 31:11 is encoded into a device number. When that field is empty, the device number becomes all ones. Both regions are little-endian, and host data travels on its natural byte lanes.

The controller has three states. ST_IDLE waits for a host access. ST_ISSUE holds the downstream request until it is acknowledged. ST_RESP returns the result to the host for one cycle. The transitions are as follows. IDLE to ISSUE is taken on a legal data-window access. IDLE to RESP is taken on an index access or on an illegal access. ISSUE to RESP is taken on downstream ready. RESP to IDLE is taken unconditionally.

Top module: `cfgx_top`

## Requirements
- R1: After reset the index register reads 0, and d_valid and h_done are low.
- R2: An index-region write updates only the index bytes enabled by the access. An index read returns the full register. Neither issues a downstream request.
- R3: With index bit 31 set, d_addr equals the index ORed with offset bits 1:0.
- R4: With index bit 31 clear and bit 0 set, d_addr equals the index with bits 2:0 cleared, ORed with offset bits 2:0.
- R5: With index bits 31 and 0 clear, d_addr has the following layout. Bits 31:11 hold the bit position (counted from 11) of the lowest set index bit in 31:11. Bits 10:8 hold index bits 10:8. Bits 7:3 hold index bits 7:3. Bits 2:0 hold offset bits 2:0.
- R6: In the R5 format with none of index bits 31:11 set, d_addr bits 31:11 are all ones.
- R7: h_size encodes the access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The byte enables are 0001 shifted by offset[1:0], 0011 shifted by offset[1:0], and 1111, respectively.
- R8: The following accesses are illegal: a 2-byte access at offset[1:0]=3, a 4-byte access with offset[1:0]≠0, and h_size=3. An illegal access completes with h_err=1 and issues no downstream request.
- R9: Each legal data access raises d_valid once, and d_valid stays asserted with stable fields until d_ready. h_done pulses for one cycle, in the cycle after acceptance.
- R10: A data read returns on h_rdata the d_rdata value present at acceptance. A data write drives d_we=1 and d_wdata=h_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host access request, held until h_done |
| h_win | input | 1 | 0 selects the index region, 1 selects the data window |
| h_we | input | 1 | 1 for a write |
| h_off | input | 12 | Byte offset within the 4 KiB region |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Write data on natural byte lanes |
| h_done | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Access rejected, valid with h_done |
| h_rdata | output | 32 | Read data, valid with h_done |
| d_valid | output | 1 | Downstream request valid |
| d_ready | input | 1 | Downstream acceptance |
| d_we | output | 1 | Downstream write flag |
| d_addr | output | 32 | Translated configuration address |
| d_be | output | 4 | Byte enables |
| d_wdata | output | 32 | Downstream write data |
| d_rdata | input | 32 | Downstream read data, sampled at acceptance |

## Verification
The host's next access can arrive in the same cycle that the downstream side accepts the previous request. The index register can also be rewritten immediately after a data access completes, so a stale or early index sample would corrupt the following translation. The bench provokes both cases in two ways: it runs accesses back to back with zero downstream stall, and it mixes in stalls of several cycles. The scoreboard pairs every accepted request with the address, enables and data the driver predicted from the index that was current when that access began. Any request that arrives while no prediction is queued is counted as a failure.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } cfgx_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } cfgx_size_e;
endpackage

// File: rtl/cfgx_xlate.sv
module cfgx_xlate #(
    parameter int ADDR_W    = 32,
    parameter int IDSEL_LSB = 11
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [2:0]        off_lo,
    output logic [ADDR_W-1:0] addr
);
    localparam int SEL_N = ADDR_W - IDSEL_LSB;
    localparam int DEV_W = $clog2(SEL_N);

    logic [DEV_W-1:0]  dev;
    logic              found;
    logic [ADDR_W-1:0] t0_addr;

    // lowest set select bit wins: scan downward, last hit kept
    always_comb begin
        found = 1'b0;
        dev   = '0;
        for (int i = ADDR_W - 1; i >= IDSEL_LSB; i--) begin
            if (idx[i]) begin
                found = 1'b1;
                dev   = DEV_W'(i - IDSEL_LSB);
            end
        end
    end

    always_comb begin
        if (found)
            t0_addr = ADDR_W'(dev) << IDSEL_LSB;
        else
            t0_addr = {ADDR_W{1'b1}} << IDSEL_LSB;
        t0_addr[IDSEL_LSB-1:3] = idx[IDSEL_LSB-1:3];
        t0_addr[2:0]           = off_lo;
    end

    always_comb begin
        if (idx[ADDR_W-1])
            addr = idx | ADDR_W'(off_lo[1:0]);
        else if (idx[0])
            addr = {idx[ADDR_W-1:3], off_lo};
        else
            addr = t0_addr;
    end
endmodule

// File: rtl/cfgx_lanes.sv
module cfgx_lanes
    import cfgx_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic [1:0]      off_lo,
    input  logic [1:0]      size,
    output logic [BE_W-1:0] be,
    output logic            legal
);
    always_comb begin
        be    = '0;
        legal = 1'b0;
        unique case (cfgx_size_e'(size))
            SZ_BYTE: begin
                legal = 1'b1;
                be    = BE_W'(1) << off_lo;
            end
            SZ_HALF: begin
                legal = (off_lo != 2'd3);
                be    = BE_W'(3) << off_lo;
            end
            SZ_WORD: begin
                legal = (off_lo == 2'd0);
                be    = '1;
            end
            SZ_BAD: begin
                legal = 1'b0;
                be    = '0;
            end
        endcase
    end
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int OFF_W     = 12,
    parameter int IDSEL_LSB = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic              h_win,
    input  logic              h_we,
    input  logic [OFF_W-1:0]  h_off,
    input  logic [1:0]        h_size,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_done,
    output logic              h_err,
    output logic [DATA_W-1:0] h_rdata,
    output logic              d_valid,
    input  logic              d_ready,
    output logic              d_we,
    output logic [ADDR_W-1:0] d_addr,
    output logic [DATA_W/8-1:0] d_be,
    output logic [DATA_W-1:0] d_wdata,
    input  logic [DATA_W-1:0] d_rdata
);
    localparam int BE_W = DATA_W / 8;

    cfgx_state_e       state, state_nx;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] xaddr;
    logic [BE_W-1:0]   be_c;
    logic              legal_c;
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic              we_q;
    logic              err_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    cfgx_xlate #(.ADDR_W(ADDR_W), .IDSEL_LSB(IDSEL_LSB)) u_xlate (
        .idx    (idx_q),
        .off_lo (h_off[2:0]),
        .addr   (xaddr)
    );

    cfgx_lanes #(.BE_W(BE_W)) u_lanes (
        .off_lo (h_off[1:0]),
        .size   (h_size),
        .be     (be_c),
        .legal  (legal_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (h_valid) begin
                    if (legal_c && h_win) state_nx = ST_ISSUE;
                    else                  state_nx = ST_RESP;
                end
            end
            ST_ISSUE: if (d_ready) state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        d_valid = (state == ST_ISSUE);
        h_done  = (state == ST_RESP);
        h_err   = err_q;
        h_rdata = rdata_q;
        d_addr  = addr_q;
        d_be    = be_q;
        d_we    = we_q;
        d_wdata = wdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && h_valid) begin
                err_q <= !legal_c;
                if (legal_c && h_win) begin
                    addr_q  <= xaddr;
                    be_q    <= be_c;
                    we_q    <= h_we;
                    wdata_q <= h_wdata;
                end else if (legal_c) begin
                    rdata_q <= idx_q;
                    if (h_we) begin
                        for (int b = 0; b < BE_W; b++) begin
                            if (be_c[b]) idx_q[b*8 +: 8] <= h_wdata[b*8 +: 8];
                        end
                    end
                end else begin
                    rdata_q <= '0;
                end
            end
            if (state == ST_ISSUE && d_ready) rdata_q <= d_rdata;
        end
    end
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              d_valid,
    input logic              d_ready,
    input logic [ADDR_W-1:0] d_addr,
    input logic [BE_W-1:0]   d_be,
    input logic              h_done,
    input logic              h_err,
    input logic [ADDR_W-1:0] idx_q
);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_be)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_done |=> !h_done);

    assert_err_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_done && h_err) |-> !d_valid);

    assert_be_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        d_valid |-> (d_be != '0));

    assert_idx_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && $past(d_valid)) |-> $stable(idx_q));

    assert_accept_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready) |=> (h_done && !d_valid));
endmodule

bind cfgx_top cfgx_chk #(.ADDR_W(ADDR_W), .BE_W(DATA_W/8)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (d_valid),
    .d_ready (d_ready),
    .d_addr  (d_addr),
    .d_be    (d_be),
    .h_done  (h_done),
    .h_err   (h_err),
    .idx_q   (idx_q)
);

// File: tb/sim_cfgx_top.sv
module sim_cfgx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_valid = 1'b0, h_win = 1'b0, h_we = 1'b0;
    logic [11:0] h_off = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic        h_done, h_err;
    logic [31:0] h_rdata;
    logic        d_valid, d_we;
    logic        d_ready = 1'b0;
    logic [31:0] d_addr, d_wdata;
    logic [31:0] d_rdata = '0;
    logic [3:0]  d_be;

    int errors = 0;
    int checks = 0;
    int stall  = 0;
    int wcnt   = 0;

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    cfgx_top u0 (
        .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_win(h_win), .h_we(h_we),
        .h_off(h_off), .h_size(h_size), .h_wdata(h_wdata), .h_done(h_done),
        .h_err(h_err), .h_rdata(h_rdata), .d_valid(d_valid), .d_ready(d_ready),
        .d_we(d_we), .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_rdata(d_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent model of the translation rules
    function automatic logic [31:0] model(input logic [31:0] idx, input logic [11:0] off);
        logic [31:0] r;
        int pos;
        if (idx[31]) return idx | {30'd0, off[1:0]};
        if (idx[0])  return {idx[31:3], off[2:0]};
        pos = -1;
        for (int i = 11; i < 32; i++) if (idx[i] && pos < 0) pos = i - 11;
        r = {21'((pos < 0) ? 21'h1FFFFF : 21'(pos)), 11'd0};
        r[10:0] = {idx[10:3], off[2:0]};
        return r;
    endfunction

    function automatic logic [3:0] bemodel(input logic [1:0] sz, input logic [1:0] o);
        case (sz)
            2'd0: return 4'b0001 << o;
            2'd1: return 4'b0011 << o;
            default: return 4'b1111;
        endcase
    endfunction

    // downstream responder and scoreboard monitor
    always @(negedge clk) begin
        if (d_ready) begin
            d_ready = 1'b0;
        end else if (d_valid) begin
            if (wcnt >= stall) begin
                wcnt = 0;
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected downstream request", d_addr, 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(d_addr == e.addr, {e.tag, " d_addr"}, d_addr, e.addr);
                    chk(d_be == e.be, "R7 d_be", {28'd0, d_be}, {28'd0, e.be});
                    chk(d_we == e.we, "R10 d_we", {31'd0, d_we}, {31'd0, e.we});
                    if (e.we) chk(d_wdata == e.wdata, "R10 d_wdata", d_wdata, e.wdata);
                end
                d_rdata = ~d_addr;
                d_ready = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    logic [31:0] cur_idx = '0;

    task automatic acc(input bit win, input bit we, input logic [11:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input bit exp_err, input logic [31:0] exp_rd,
                       input bit chk_rd, input string tag);
        exp_t e;
        if (win && !exp_err) begin
            e.addr = model(cur_idx, off);
            e.be = bemodel(sz, off[1:0]);
            e.we = we; e.wdata = wd; e.tag = tag;
            q.push_back(e);
        end
        h_win = win; h_we = we; h_off = off; h_size = sz; h_wdata = wd; h_valid = 1'b1;
        do @(negedge clk); while (!h_done);
        chk(h_err == exp_err, {tag, " h_err"}, {31'd0, h_err}, {31'd0, exp_err});
        if (chk_rd) chk(h_rdata == exp_rd, {tag, " h_rdata"}, h_rdata, exp_rd);
        chk(q.size() == 0, {tag, " request count"}, q.size(), 0);
        h_valid = 1'b0;
    endtask

    task automatic set_idx(input logic [31:0] v);
        acc(1'b0, 1'b1, 12'h0, 2'd2, v, 1'b0, 32'h0, 1'b0, "R2 index write");
        cur_idx = v;
    endtask

    task automatic run();
        repeat (3) @(negedge clk);
        chk(!h_done && !d_valid, "R1 reset outputs", {30'd0, h_done, d_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        acc(1'b0, 1'b0, 12'h0, 2'd2, 0, 1'b0, 32'h0, 1'b1, "R1 index after reset");

        set_idx(32'h8000_1234);
        acc(1'b0, 1'b0, 12'h0, 2'd2, 0, 1'b0, 32'h8000_1234, 1'b1, "R2 index readback");
        // partial index write: byte lane 1 only
        acc(1'b0, 1'b1, 12'h001, 2'd0, 32'h0000_AB00, 1'b0, 32'h0, 1'b0, "R2 byte write");
        cur_idx = 32'h8000_AB34;
        acc(1'b0, 1'b0, 12'h0, 2'd2, 0, 1'b0, cur_idx, 1'b1, "R2 partial readback");

        stall = 0;
        acc(1'b1, 1'b0, 12'h002, 2'd0, 0, 1'b0, ~model(cur_idx, 12'h002), 1'b1, "R3 passthrough read");
        acc(1'b1, 1'b0, 12'h003, 2'd0, 0, 1'b0, ~model(cur_idx, 12'h003), 1'b1, "R3 passthrough read b3");

        set_idx(32'h0005_0301);
        stall = 3;
        acc(1'b1, 1'b1, 12'h006, 2'd1, 32'hBEEF_0000, 1'b0, 0, 1'b0, "R4 type1 write");
        acc(1'b1, 1'b0, 12'h005, 2'd0, 0, 1'b0, ~32'h0005_0305, 1'b1, "R4 type1 read");

        set_idx(32'h0002_05AA);
        stall = 0;
        acc(1'b1, 1'b0, 12'h001, 2'd0, 0, 1'b0, ~32'h0000_35A9, 1'b1, "R5 type0 bit17");
        set_idx(32'h4000_1300);
        stall = 2;
        acc(1'b1, 1'b1, 12'h000, 2'd2, 32'h1122_3344, 1'b0, 0, 1'b0, "R5 type0 lowest of two");
        acc(1'b1, 1'b0, 12'h000, 2'd2, 0, 1'b0, ~32'h0000_0B00, 1'b1, "R5 type0 readback value");

        set_idx(32'h0000_07F0);
        stall = 0;
        acc(1'b1, 1'b0, 12'h004, 2'd2, 0, 1'b0, ~32'hFFFF_FFF4, 1'b1, "R6 no select bit");
        acc(1'b1, 1'b1, 12'h002, 2'd1, 32'h5566_0000, 1'b0, 0, 1'b0, "R6 half write");

        acc(1'b1, 1'b0, 12'h003, 2'd1, 0, 1'b1, 32'h0, 1'b0, "R8 half at 3");
        acc(1'b1, 1'b1, 12'h002, 2'd2, 32'h1, 1'b1, 32'h0, 1'b0, "R8 word misaligned");
        acc(1'b1, 1'b0, 12'h000, 2'd3, 0, 1'b1, 32'h0, 1'b0, "R8 bad size");
        acc(1'b0, 1'b1, 12'h001, 2'd2, 32'hFFFF_FFFF, 1'b1, 32'h0, 1'b0, "R8 index misaligned");
        acc(1'b0, 1'b0, 12'h0, 2'd2, 0, 1'b0, cur_idx, 1'b1, "R8 index untouched");

        // back-to-back, zero stall, index changes between accesses (R9)
        stall = 0;
        for (int k = 0; k < 4; k++) begin
            set_idx(32'h0000_0800 << k);
            acc(1'b1, 1'b0, 12'(k), 2'd0, 0, 1'b0, ~model(cur_idx, 12'(k)), 1'b1, "R9 back to back");
        end
        repeat (3) @(negedge clk);
        chk(!d_valid && !h_done, "R9 idle after run", {30'd0, d_valid, h_done}, 32'h0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL R9 watchdog expired actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule